// File: doc/BRIEF.md
# VME slave to mezzanine bridge

This block is the slave side of a VMEbus carrier that holds five mezzanine I/O modules in slots A to E. It watches short-address (A16) cycles. An access is taken only when address bits A15..A11 match the five base-select inputs, which places the board on one of 32 bases, each 2 KB apart. Inside the 2 KB window an access goes to one of three places: the I/O space of a module, the ID space of a module, or a small bank of carrier registers. The carrier registers are five general-purpose bytes, one per slot, plus an error byte and a module-reset byte.

A module access drives a per-slot select for I/O or ID space and then waits, for as many wait states as the module needs, until that module pulls its active-low acknowledge. Read data is captured on the clock edge that sees the acknowledge. The VME data bus is driven one cycle before DTACK falls. If a module never answers, a timeout sets that slot's error bit and the cycle ends with all-ones read data. Once DTACK is low, it and the read data are held until the master releases AS and both DS lines. Each accepted cycle produces a one-clock strobe on a per-target line, for a neighbouring LED and reset driver.

Top module: `vme_mezz_bridge`

## Requirements
- R1: A cycle is accepted only when addr_i[15:11] equals base_sel_i. A cycle at any other base gets no DTACK, no strobe and no select.
- R2: Only address modifiers 6'h29 and 6'h2D are accepted. Under any other modifier the cycle gets no DTACK, and a register write under it has no effect.
- R3: Window offsets 0x000 + 0x80*s (s = 0..4) map to I/O space of slot s, with module address = addr_i[6:1]. Offsets 0x400 + 0x40*s map to ID space of slot s, with module address = {0, addr_i[5:1]}. Only the one select for that slot and space goes low. DTACK is never low while a select is low, and it falls exactly 4 + w cycles after the cycle starts, where w is the number of wait states the module inserts.
- R4: Read data is taken on the edge where the module acknowledges. dat_oe_o is high with that data one cycle before DTACK falls.
- R5: A word read of a carrier register returns 8'hFF in the upper byte. In the lower byte, bits that the register does not implement read as 0. DTACK falls 2 cycles after the start.
- R6: General-purpose registers for slots 0..4 sit at offsets 0x600 + 2*s and reset to 0. Writes update them only when ds_n_i[0] (the lower byte lane) is low. A write with only ds_n_i[1] low leaves them unchanged.
- R7: After DTACK falls, DTACK and the read data stay put while AS or either DS is low. They are released one clock after AS and both DS go high.
- R8: If a module does not acknowledge within TIMEOUT_CYC cycles, error bit s of the register at 0x610 is set and the cycle ends with DTACK and read data 16'hFFFF. Writing ones to 0x610 through the lower lane clears those bits.
- R9: Each accepted cycle raises strobe_o for exactly one cycle, while in idle with the cycle present. Bit s marks slot s and bit 5 marks the carrier registers.
- R10: Writing a 1 to bit s of the register at 0x612 drives mod_rst_o[s] high for RST_CYCLES clocks. Reading 0x612 returns the reset bits that are still active.
- R11: Offsets outside the mapped areas, including I/O or ID space of a slot number 5 or above, get no DTACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_sel_i | input | 5 | Board base, compared with A15..A11 |
| am_i | input | 6 | VME address modifier |
| addr_i | input | 15 | VME address A15..A1 |
| as_n_i | input | 1 | Address strobe, active low |
| ds_n_i | input | 2 | Data strobes, bit 0 is the lower byte lane |
| write_n_i | input | 1 | Low for a write cycle |
| dat_i | input | 16 | VME write data |
| dat_o | output | 16 | VME read data |
| dat_oe_o | output | 1 | Read data drive enable |
| dtack_n_o | output | 1 | Data acknowledge, active low |
| mod_sel_io_n_o | output | 5 | Per-slot I/O space select, active low |
| mod_sel_id_n_o | output | 5 | Per-slot ID space select, active low |
| mod_addr_o | output | 6 | Module word address |
| mod_dat_o | output | 16 | Module write data |
| mod_we_n_o | output | 1 | Module write enable, active low |
| mod_be_n_o | output | 2 | Module byte lanes, active low |
| mod_dat_i | input | 80 | Module read data, 16 bits per slot |
| mod_ack_ni | input | 5 | Per-slot module acknowledge, active low |
| mod_rst_o | output | 5 | Per-slot module reset request |
| strobe_o | output | 6 | One-cycle access strobe per slot, bit 5 for carrier registers |

## Verification
The checks assume several things about the master. It holds address, modifier, write line and write data steady while AS is low. It never asserts a data strobe without AS. Its signals are already synchronous to the module clock. The checks also assume that a module keeps its acknowledge low only while its own select is low. The bench drives every cycle through one task that sets all master signals together on a falling clock edge and releases AS and DS together. Its module model answers only on its own slot's select and lifts the acknowledge as soon as the select returns high.

// File: rtl/vmb_pkg.sv
package vmb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MOD, ST_DATA, ST_DONE} st_e;
  typedef enum logic [1:0] {TGT_NONE, TGT_IO, TGT_ID, TGT_REG} tgt_e;
  localparam logic [5:0] AM_SHORT_USR = 6'h29;
  localparam logic [5:0] AM_SHORT_SUP = 6'h2D;
  localparam int unsigned DW  = 16;
  localparam int unsigned MAW = 6;
endpackage

// File: rtl/vmb_decode.sv
module vmb_decode
  import vmb_pkg::*;
#(
  parameter int unsigned N_SLOT = 5,
  parameter int unsigned SLOT_W = 3
) (
  input  logic [15:1]       addr_i,
  input  logic [5:0]        am_i,
  input  logic [4:0]        base_i,
  output tgt_e              tgt_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [2:0]        reg_o,
  output logic [MAW-1:0]    maddr_o
);
  logic am_ok, base_ok;

  always_comb begin
    am_ok   = (am_i == AM_SHORT_USR) || (am_i == AM_SHORT_SUP);
    base_ok = (addr_i[15:11] == base_i);
    tgt_o   = TGT_NONE;
    slot_o  = '0;
    reg_o   = '0;
    maddr_o = '0;
    if (am_ok && base_ok) begin
      if (!addr_i[10] && int'(addr_i[9:7]) < N_SLOT) begin
        tgt_o   = TGT_IO;
        slot_o  = SLOT_W'(addr_i[9:7]);
        maddr_o = addr_i[6:1];
      end else if (addr_i[10:9] == 2'b10 && int'(addr_i[8:6]) < N_SLOT) begin
        tgt_o   = TGT_ID;
        slot_o  = SLOT_W'(addr_i[8:6]);
        maddr_o = {1'b0, addr_i[5:1]};
      end else if (addr_i[10:4] == 7'h60 && int'(addr_i[3:1]) < N_SLOT) begin
        tgt_o = TGT_REG;
        reg_o = addr_i[3:1];
      end else if (addr_i[10:4] == 7'h61 && addr_i[3:2] == 2'b00) begin
        tgt_o = TGT_REG;
        reg_o = 3'(N_SLOT + int'(addr_i[1]));
      end
    end
  end
endmodule

// File: rtl/vmb_cregs.sv
module vmb_cregs #(
  parameter int unsigned N_SLOT     = 5,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        idx_i,
  input  logic [7:0]        wdat_i,
  input  logic [N_SLOT-1:0] err_set_i,
  output logic [7:0]        rdat_o,
  output logic [N_SLOT-1:0] mod_rst_o
);
  localparam int unsigned IDX_ERR = N_SLOT;
  localparam int unsigned IDX_RST = N_SLOT + 1;
  localparam int unsigned RCW     = $clog2(RST_CYCLES + 1);

  logic [7:0]        gpr_q [N_SLOT];
  logic [N_SLOT-1:0] err_q, rst_q;
  logic [RCW-1:0]    rcnt_q;
  logic              wr_err, wr_rst;

  assign wr_err = wr_i && (int'(idx_i) == IDX_ERR);
  assign wr_rst = wr_i && (int'(idx_i) == IDX_RST) && (|wdat_i[N_SLOT-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SLOT; i++) gpr_q[i] <= '0;
    end else if (wr_i) begin
      for (int i = 0; i < N_SLOT; i++)
        if (int'(idx_i) == i) gpr_q[i] <= wdat_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else if (wr_err) err_q <= (err_q & ~wdat_i[N_SLOT-1:0]) | err_set_i;
    else err_q <= err_q | err_set_i;
  end

  // shared hold counter, reloaded by every reset write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= '0;
      rcnt_q <= '0;
    end else if (wr_rst) begin
      rst_q  <= rst_q | wdat_i[N_SLOT-1:0];
      rcnt_q <= RCW'(RST_CYCLES - 1);
    end else if (rcnt_q != '0) begin
      rcnt_q <= rcnt_q - 1'b1;
    end else begin
      rst_q <= '0;
    end
  end

  always_comb begin
    rdat_o = '0;
    if (int'(idx_i) < N_SLOT) rdat_o = gpr_q[idx_i];
    else if (int'(idx_i) == IDX_ERR) rdat_o = 8'(err_q);
    else if (int'(idx_i) == IDX_RST) rdat_o = 8'(rst_q);
  end

  assign mod_rst_o = rst_q;
endmodule

// File: rtl/vmb_ctrl.sv
module vmb_ctrl
  import vmb_pkg::*;
#(
  parameter int unsigned N_SLOT      = 5,
  parameter int unsigned SLOT_W      = 3,
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               as_n_i,
  input  logic [1:0]         ds_n_i,
  input  logic               write_n_i,
  input  logic [DW-1:0]      dat_i,
  input  tgt_e               tgt_i,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [MAW-1:0]     maddr_i,
  input  logic [7:0]         creg_rdat_i,
  input  logic [N_SLOT*DW-1:0] mod_dat_i,
  input  logic [N_SLOT-1:0]  mod_ack_ni,
  output logic               dtack_n_o,
  output logic               dat_oe_o,
  output logic [DW-1:0]      dat_o,
  output logic [N_SLOT-1:0]  sel_io_n_o,
  output logic [N_SLOT-1:0]  sel_id_n_o,
  output logic [MAW-1:0]     mod_addr_o,
  output logic [DW-1:0]      mod_dat_o,
  output logic               mod_we_n_o,
  output logic [1:0]         mod_be_n_o,
  output logic               reg_wr_o,
  output logic [N_SLOT-1:0]  err_set_o,
  output logic [N_SLOT:0]    strobe_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC);

  st_e               st_q;
  logic [SLOT_W-1:0] slot_q;
  logic              is_id_q, we_n_q;
  logic [1:0]        be_n_q;
  logic [MAW-1:0]    maddr_q;
  logic [DW-1:0]     wdat_q, rdat_q;
  logic [CW-1:0]     cnt_q;
  logic              start, acked, expired;

  assign start   = (st_q == ST_IDLE) && !as_n_i && !(&ds_n_i) && (tgt_i != TGT_NONE);
  assign acked   = !mod_ack_ni[slot_q];
  assign expired = (cnt_q == CW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      slot_q  <= '0;
      is_id_q <= 1'b0;
      we_n_q  <= 1'b1;
      be_n_q  <= 2'b11;
      maddr_q <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          slot_q  <= slot_i;
          is_id_q <= (tgt_i == TGT_ID);
          we_n_q  <= write_n_i;
          be_n_q  <= ds_n_i;
          maddr_q <= maddr_i;
          wdat_q  <= dat_i;
          cnt_q   <= '0;
          if (tgt_i == TGT_REG) begin
            rdat_q <= {8'hFF, creg_rdat_i};
            st_q   <= ST_DATA;
          end else begin
            st_q <= ST_MOD;
          end
        end
        ST_MOD: begin
          if (acked) begin
            rdat_q <= mod_dat_i[int'(slot_q)*DW +: DW];
            st_q   <= ST_DATA;
          end else if (expired) begin
            rdat_q <= '1;
            st_q   <= ST_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: st_q <= ST_DONE;
        ST_DONE: if (as_n_i && (&ds_n_i)) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic hit;
    assign hit           = (st_q == ST_MOD) && (int'(slot_q) == g);
    assign sel_io_n_o[g] = !(hit && !is_id_q);
    assign sel_id_n_o[g] = !(hit && is_id_q);
    assign err_set_o[g]  = hit && !acked && expired;
    assign strobe_o[g]   = start && (tgt_i != TGT_REG) && (int'(slot_i) == g);
  end
  assign strobe_o[N_SLOT] = start && (tgt_i == TGT_REG);

  assign reg_wr_o   = start && (tgt_i == TGT_REG) && !write_n_i && !ds_n_i[0];
  assign dtack_n_o  = (st_q != ST_DONE);
  assign dat_oe_o   = ((st_q == ST_DATA) || (st_q == ST_DONE)) && we_n_q;
  assign dat_o      = rdat_q;
  assign mod_addr_o = maddr_q;
  assign mod_dat_o  = wdat_q;
  assign mod_we_n_o = we_n_q;
  assign mod_be_n_o = be_n_q;
endmodule

// File: rtl/vme_mezz_bridge.sv
module vme_mezz_bridge
  import vmb_pkg::*;
#(
  parameter int unsigned N_SLOT      = 5,
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter int unsigned RST_CYCLES  = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [4:0]           base_sel_i,
  input  logic [5:0]           am_i,
  input  logic [15:1]          addr_i,
  input  logic                 as_n_i,
  input  logic [1:0]           ds_n_i,
  input  logic                 write_n_i,
  input  logic [15:0]          dat_i,
  output logic [15:0]          dat_o,
  output logic                 dat_oe_o,
  output logic                 dtack_n_o,
  output logic [N_SLOT-1:0]    mod_sel_io_n_o,
  output logic [N_SLOT-1:0]    mod_sel_id_n_o,
  output logic [5:0]           mod_addr_o,
  output logic [15:0]          mod_dat_o,
  output logic                 mod_we_n_o,
  output logic [1:0]           mod_be_n_o,
  input  logic [N_SLOT*16-1:0] mod_dat_i,
  input  logic [N_SLOT-1:0]    mod_ack_ni,
  output logic [N_SLOT-1:0]    mod_rst_o,
  output logic [N_SLOT:0]      strobe_o
);
  localparam int unsigned SLOT_W = $clog2(N_SLOT);

  tgt_e              tgt;
  logic [SLOT_W-1:0] slot;
  logic [2:0]        reg_idx;
  logic [MAW-1:0]    maddr;
  logic [7:0]        creg_rdat;
  logic              reg_wr;
  logic [N_SLOT-1:0] err_set;

  vmb_decode #(.N_SLOT(N_SLOT), .SLOT_W(SLOT_W)) u_dec (
    .addr_i (addr_i),
    .am_i   (am_i),
    .base_i (base_sel_i),
    .tgt_o  (tgt),
    .slot_o (slot),
    .reg_o  (reg_idx),
    .maddr_o(maddr)
  );

  vmb_cregs #(.N_SLOT(N_SLOT), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr),
    .idx_i    (reg_idx),
    .wdat_i   (dat_i[7:0]),
    .err_set_i(err_set),
    .rdat_o   (creg_rdat),
    .mod_rst_o(mod_rst_o)
  );

  vmb_ctrl #(.N_SLOT(N_SLOT), .SLOT_W(SLOT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .as_n_i     (as_n_i),
    .ds_n_i     (ds_n_i),
    .write_n_i  (write_n_i),
    .dat_i      (dat_i),
    .tgt_i      (tgt),
    .slot_i     (slot),
    .maddr_i    (maddr),
    .creg_rdat_i(creg_rdat),
    .mod_dat_i  (mod_dat_i),
    .mod_ack_ni (mod_ack_ni),
    .dtack_n_o  (dtack_n_o),
    .dat_oe_o   (dat_oe_o),
    .dat_o      (dat_o),
    .sel_io_n_o (mod_sel_io_n_o),
    .sel_id_n_o (mod_sel_id_n_o),
    .mod_addr_o (mod_addr_o),
    .mod_dat_o  (mod_dat_o),
    .mod_we_n_o (mod_we_n_o),
    .mod_be_n_o (mod_be_n_o),
    .reg_wr_o   (reg_wr),
    .err_set_o  (err_set),
    .strobe_o   (strobe_o)
  );
endmodule

// File: rtl/vmb_chk.sv
module vmb_chk
  import vmb_pkg::*;
#(
  parameter int unsigned N_SLOT = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [5:0]        am_i,
  input logic              as_n_i,
  input logic [1:0]        ds_n_i,
  input logic              write_n_i,
  input logic              dat_oe_o,
  input logic              dtack_n_o,
  input logic [N_SLOT-1:0] mod_sel_io_n_o,
  input logic [N_SLOT-1:0] mod_sel_id_n_o,
  input logic [N_SLOT:0]   strobe_o
);
  logic bad_am, any_sel;
  assign bad_am  = (am_i != AM_SHORT_USR) && (am_i != AM_SHORT_SUP);
  assign any_sel = !((&mod_sel_io_n_o) && (&mod_sel_id_n_o));

  a_r2_bad_am_no_dtack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_n_i && bad_am) |=> dtack_n_o);

  a_r3_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{mod_sel_io_n_o, mod_sel_id_n_o}));

  a_r3_no_dtack_while_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_sel |-> dtack_n_o);

  a_r4_data_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dtack_n_o) && write_n_i) |-> $past(dat_oe_o));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_n_o && !as_n_i) |=> !dtack_n_o);

  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_n_o && as_n_i && (&ds_n_i)) |=> dtack_n_o);

  a_r9_strobe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));

  a_r9_strobe_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|strobe_o) |=> !(|strobe_o));
endmodule

bind vme_mezz_bridge vmb_chk #(.N_SLOT(N_SLOT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .am_i          (am_i),
  .as_n_i        (as_n_i),
  .ds_n_i        (ds_n_i),
  .write_n_i     (write_n_i),
  .dat_oe_o      (dat_oe_o),
  .dtack_n_o     (dtack_n_o),
  .mod_sel_io_n_o(mod_sel_io_n_o),
  .mod_sel_id_n_o(mod_sel_id_n_o),
  .strobe_o      (strobe_o)
);

// File: tb/vme_mezz_bridge_tb_top.sv
`timescale 1ns/1ps
module vme_mezz_bridge_tb_top;
  localparam int NS = 5;
  localparam int RSTC = 32;
  localparam logic [4:0] BASE = 5'b10110;
  localparam logic [15:0] BA = {BASE, 11'd0};
  localparam logic [5:0] AM_OK = 6'h2D;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0]  am_i = AM_OK;
  logic [15:1] addr_i = '0;
  logic        as_n_i = 1'b1;
  logic [1:0]  ds_n_i = 2'b11;
  logic        write_n_i = 1'b1;
  logic [15:0] dat_i = '0;
  logic [15:0] dat_o;
  logic        dat_oe_o, dtack_n_o, mod_we_n_o;
  logic [NS-1:0] sel_io, sel_id, mod_rst_o;
  logic [5:0]  mod_addr_o;
  logic [15:0] mod_dat_o;
  logic [1:0]  mod_be_n_o;
  logic [NS*16-1:0] mod_dat;
  logic [NS-1:0] ack_n = '1;
  logic [NS:0] strobe_o;

  vme_mezz_bridge #(.N_SLOT(NS), .TIMEOUT_CYC(64), .RST_CYCLES(RSTC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .base_sel_i(BASE), .am_i(am_i), .addr_i(addr_i),
    .as_n_i(as_n_i), .ds_n_i(ds_n_i), .write_n_i(write_n_i), .dat_i(dat_i),
    .dat_o(dat_o), .dat_oe_o(dat_oe_o), .dtack_n_o(dtack_n_o),
    .mod_sel_io_n_o(sel_io), .mod_sel_id_n_o(sel_id), .mod_addr_o(mod_addr_o),
    .mod_dat_o(mod_dat_o), .mod_we_n_o(mod_we_n_o), .mod_be_n_o(mod_be_n_o),
    .mod_dat_i(mod_dat), .mod_ack_ni(ack_n), .mod_rst_o(mod_rst_o), .strobe_o(strobe_o)
  );

  // module model
  int          wait_cyc [NS];
  bit          resp_en  [NS];
  int          mcnt     [NS];
  logic [15:0] last_wd  [NS];
  logic [5:0]  last_wa  [NS];

  initial for (int i = 0; i < NS; i++) begin
    wait_cyc[i] = 0; resp_en[i] = 1'b1; mcnt[i] = 0; last_wd[i] = '0; last_wa[i] = '0;
  end

  always_comb for (int i = 0; i < NS; i++)
    mod_dat[i*16 +: 16] = {(!sel_id[i] ? 8'hD0 : 8'hC0) | 8'(i), 2'b00, mod_addr_o};

  always @(posedge clk) for (int i = 0; i < NS; i++) begin
    if (!sel_io[i] || !sel_id[i]) begin
      if (resp_en[i] && mcnt[i] >= wait_cyc[i]) begin
        ack_n[i] <= 1'b0;
        if (!mod_we_n_o) begin last_wd[i] <= mod_dat_o; last_wa[i] <= mod_addr_o; end
      end
      mcnt[i] <= mcnt[i] + 1;
    end else begin
      ack_n[i] <= 1'b1;
      mcnt[i]  <= 0;
    end
  end

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic vme_cyc(input logic [15:0] a, input logic wr, input logic [1:0] ds,
                         input logic [15:0] wd, input logic [5:0] am, input int limit,
                         output logic acked, output logic [15:0] rd, output int lat,
                         output logic [5:0] stb);
    logic prev_oe;
    @(negedge clk);
    addr_i = a[15:1]; am_i = am; write_n_i = !wr; dat_i = wd; ds_n_i = ds; as_n_i = 1'b0;
    #1 stb = strobe_o;
    acked = 1'b0; lat = 0; prev_oe = 1'b0; rd = '0;
    while (!acked && lat < limit) begin
      @(negedge clk);
      lat++;
      if (!dtack_n_o) acked = 1'b1;
      else prev_oe = dat_oe_o;
    end
    if (acked) begin
      rd = dat_o;
      if (!wr) chk(prev_oe && dat_oe_o, "R4 data driven before DTACK", {30'd0, prev_oe, dat_oe_o}, 32'h3);
      repeat (2) @(negedge clk);
      chk(!dtack_n_o && (wr || dat_o == rd), "R7 hold while strobes low", {15'd0, dtack_n_o, dat_o}, {16'd0, rd});
    end
    as_n_i = 1'b1; ds_n_i = 2'b11;
    @(negedge clk);
    chk(dtack_n_o && !dat_oe_o, "R7 release after strobes high", {30'd0, dtack_n_o, dat_oe_o}, 32'h2);
  endtask

  task automatic rd_reg(input logic [15:0] off, input logic [15:0] exp, input string tag);
    logic ok; logic [15:0] rd; int lat; logic [5:0] stb;
    vme_cyc(BA | off, 1'b0, 2'b00, 16'h0, AM_OK, 20, ok, rd, lat, stb);
    chk(ok && rd == exp, tag, {15'd0, ok, rd}, {16'h1, exp});
  endtask

  task automatic wr_reg(input logic [15:0] off, input logic [1:0] ds, input logic [15:0] wd);
    logic ok; logic [15:0] rd; int lat; logic [5:0] stb;
    vme_cyc(BA | off, 1'b1, ds, wd, AM_OK, 20, ok, rd, lat, stb);
    chk(ok && stb == 6'h20, "R9 carrier write strobe", {25'd0, ok, stb}, 32'h60);
  endtask

  task automatic t_reset;
    chk(dtack_n_o && !dat_oe_o && strobe_o == 0, "R7 reset idle outputs", {24'd0, dtack_n_o, dat_oe_o, strobe_o}, 32'h80);
    chk(&sel_io && &sel_id && mod_rst_o == 0, "R3 reset selects idle", {17'd0, sel_io, sel_id, mod_rst_o}, {17'd0, 10'h3FF, 5'h0});
    rd_reg(16'h600, 16'hFF00, "R6 general register resets to zero");
    rd_reg(16'h610, 16'hFF00, "R8 error register resets to zero");
  endtask

  task automatic t_carrier_regs;
    logic ok; logic [15:0] rd; int lat; logic [5:0] stb;
    wr_reg(16'h600, 2'b00, 16'h3C5A);
    vme_cyc(BA | 16'h600, 1'b0, 2'b00, 16'h0, AM_OK, 20, ok, rd, lat, stb);
    chk(ok && rd == 16'hFF5A, "R5 word read upper byte ones", {15'd0, ok, rd}, 32'h1FF5A);
    chk(lat == 2, "R5 carrier latency", lat, 2);
    chk(stb == 6'h20, "R9 carrier read strobe bit 5", stb, 32'h20);
    wr_reg(16'h603, 2'b10, 16'h0077);
    rd_reg(16'h602, 16'hFF77, "R6 byte write on lower lane");
    wr_reg(16'h604, 2'b01, 16'h1100);
    rd_reg(16'h604, 16'hFF00, "R6 upper-lane-only write ignored");
    wr_reg(16'h608, 2'b00, 16'h00E5);
    rd_reg(16'h608, 16'hFFE5, "R6 slot E register");
    rd_reg(16'h600, 16'hFF5A, "R6 slot A register kept");
  endtask

  task automatic t_module_io;
    logic ok; logic [15:0] rd; int lat; logic [5:0] stb;
    for (int w = 0; w <= 5; w += 5) begin
      wait_cyc[1] = w;
      vme_cyc(BA | 16'h092, 1'b0, 2'b00, 16'h0, AM_OK, 100, ok, rd, lat, stb);
      chk(ok && rd == 16'hC109, "R3 I/O read slot 1 data", {15'd0, ok, rd}, 32'h1C109);
      chk(lat == 4 + w, "R3 DTACK after module wait states", lat, 4 + w);
      chk(stb == 6'h02, "R9 module strobe bit 1", stb, 32'h02);
    end
    wait_cyc[1] = 0;
    // select observed during a long wait
    wait_cyc[0] = 3;
    fork
      vme_cyc(BA | 16'h004, 1'b0, 2'b00, 16'h0, AM_OK, 100, ok, rd, lat, stb);
      begin
        repeat (2) @(negedge clk);
        chk(sel_io == 5'b11110 && &sel_id && dtack_n_o, "R3 only slot 0 I/O select low",
            {26'd0, sel_io, dtack_n_o}, {26'd0, 5'b11110, 1'b1});
      end
    join
    chk(ok && rd == 16'hC002, "R3 I/O read slot 0 data", {15'd0, ok, rd}, 32'h1C002);
    wait_cyc[0] = 0;
  endtask

  task automatic t_module_id;
    logic ok; logic [15:0] rd; int lat; logic [5:0] stb;
    vme_cyc(BA | 16'h4CA, 1'b1, 2'b00, 16'h1234, AM_OK, 100, ok, rd, lat, stb);
    chk(ok && last_wd[3] == 16'h1234 && last_wa[3] == 6'd5, "R3 ID write slot 3",
        {9'd0, ok, last_wa[3], last_wd[3]}, {9'd1, 6'd5, 16'h1234});
    vme_cyc(BA | 16'h504, 1'b0, 2'b00, 16'h0, AM_OK, 100, ok, rd, lat, stb);
    chk(ok && rd == 16'hD402, "R4 ID read slot 4 data", {15'd0, ok, rd}, 32'h1D402);
  endtask

  task automatic t_timeout;
    logic ok; logic [15:0] rd; int lat; logic [5:0] stb;
    resp_en[2] = 1'b0;
    vme_cyc(BA | 16'h100, 1'b0, 2'b00, 16'h0, AM_OK, 100, ok, rd, lat, stb);
    chk(ok && rd == 16'hFFFF, "R8 timeout ends cycle with ones", {15'd0, ok, rd}, 32'h1FFFF);
    resp_en[2] = 1'b1;
    rd_reg(16'h610, 16'hFF04, "R8 slot 2 error bit set");
    wr_reg(16'h611, 2'b10, 16'h0004);
    rd_reg(16'h610, 16'hFF00, "R8 error bit cleared by write");
  endtask

  task automatic t_reset_reg;
    wr_reg(16'h612, 2'b00, 16'h0009);
    chk(mod_rst_o == 5'b01001, "R10 reset outputs asserted", mod_rst_o, 32'h09);
    rd_reg(16'h612, 16'hFF09, "R10 reset register readback");
    repeat (RSTC + 4) @(negedge clk);
    chk(mod_rst_o == 0, "R10 reset outputs self-clear", mod_rst_o, 0);
    rd_reg(16'h612, 16'hFF00, "R10 reset register cleared");
  endtask

  task automatic t_decode_miss;
    logic ok; logic [15:0] rd; int lat; logic [5:0] stb;
    vme_cyc(16'h3600, 1'b0, 2'b00, 16'h0, AM_OK, 20, ok, rd, lat, stb);
    chk(!ok && stb == 0, "R1 other base ignored", {25'd0, ok, stb}, 0);
    vme_cyc(BA | 16'h600, 1'b0, 2'b00, 16'h0, 6'h3D, 20, ok, rd, lat, stb);
    chk(!ok && stb == 0, "R2 bad modifier read ignored", {25'd0, ok, stb}, 0);
    vme_cyc(BA | 16'h600, 1'b1, 2'b00, 16'h0099, 6'h3D, 20, ok, rd, lat, stb);
    chk(!ok, "R2 bad modifier write no DTACK", ok, 0);
    rd_reg(16'h600, 16'hFF5A, "R2 bad modifier write had no effect");
    vme_cyc(BA | 16'h700, 1'b0, 2'b00, 16'h0, AM_OK, 20, ok, rd, lat, stb);
    chk(!ok, "R11 unmapped offset", ok, 0);
    vme_cyc(BA | 16'h280, 1'b0, 2'b00, 16'h0, AM_OK, 20, ok, rd, lat, stb);
    chk(!ok && stb == 0, "R11 I/O slot 5 unmapped", {25'd0, ok, stb}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_carrier_regs;
    t_module_io;
    t_module_id;
    t_timeout;
    t_reset_reg;
    t_decode_miss;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule